// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block chooses one interrupt from up to `NUM_SRC` pending sources and presents it to a processor through one active-high request line. Masking and edge or level capture happen upstream, so every bit of `src_pending` is already a live request. Each source has a 3-bit priority. The highest priority wins. When two sources share a priority, the source with the lower number wins.

Software acknowledges a request with a one-cycle vector read strobe. The read commits the source shown on `vec_data` in that cycle and makes its priority the current level. When an interrupt is already in service, the read also saves the interrupted level on a last-in-first-out stack. A one-cycle end-of-interrupt strobe restores the most recently saved level. When the stack is empty, that strobe returns the block to idle.

Both strobes are single-cycle commands with no back-pressure. The block accepts each one in the cycle it is high, and `vec_data` is valid in that same cycle. Nothing is buffered, so the sender must not repeat a strobe to retry.

Top module: `nest_irq_arbiter`

## Requirements
- R1: Source i takes its priority from `src_prio[i*3 +: 3]`. Among pending sources, the one with the numerically highest priority is selected, and 7 is the top priority.
- R2: When several pending sources share the highest priority, the one with the lowest source number is selected.
- R3: In idle (`in_service` low), `irq_o` is high whenever any source is pending. While in service, `irq_o` is high only when the selected source's priority is strictly greater than `cur_level`.
- R4: `vec_data` is the selected source number zero-extended to 6 bits while `irq_o` is high, and 6'h3F otherwise. The vector therefore always reflects the current selection, including a higher source that arrived after `irq_o` rose but before the read.
- R5: A vector read while `irq_o` is high sets `cur_level` to the selected priority and sets `in_service`. From then on, only a strictly higher priority re-asserts `irq_o`.
- R6: A vector read while `irq_o` is high and an interrupt is already in service pushes the old `cur_level`, and `nest_depth` rises by one. When the stack is full (`nest_depth` equals `STACK_DEPTH`), the push is dropped but the level still updates.
- R7: An end-of-interrupt write with a non-empty stack pops the top entry into `cur_level`. With an empty stack it clears `in_service` and sets `cur_level` to 0.
- R8: A vector read while `irq_o` is low returns 6'h3F and changes neither `cur_level`, `in_service` nor `nest_depth`.
- R9: A vector read (with `irq_o` high) and an end-of-interrupt write in the same cycle replace the running interrupt. `cur_level` takes the new priority, `in_service` stays set, and `nest_depth` does not change.
- R10: After reset, `in_service` is 0, `cur_level` is 0 and `nest_depth` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pending | input | NUM_SRC | Pending, already unmasked requests |
| src_prio | input | NUM_SRC*3 | Packed per-source priorities |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_rd | input | 1 | Vector read strobe |
| vec_data | output | SRC_W+1 | Selected source number, or all ones |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| cur_level | output | 3 | Current priority level |
| in_service | output | 1 | An interrupt is being serviced |
| nest_depth | output | $clog2(STACK_DEPTH+1) | Number of saved levels |

## Verification
The vector read and the end-of-interrupt write can land in the same cycle. The bench provokes this by raising a priority-7 source during a priority-6 service routine, then pulsing both strobes together. It judges the result by checking that the returned vector is the new source, that the level becomes 7 and that the stack depth does not move. A second collision covered is a new source arriving before the read, which must change the vector that the read returns. A small instance with a two-entry stack reaches the full-stack case.

// File: rtl/nia_pkg.sv
package nia_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/nia_prio_tree.sv
module nia_prio_tree
  import nia_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      win_valid,
  output prio_t                     win_prio,
  output logic [SRC_W-1:0]          win_idx
);
  localparam int LEAVES = 1 << SRC_W;
  localparam int NODES  = 2 * LEAVES;

  // heap-ordered tree: node 1 is the root, children of n are 2n and 2n+1
  logic             nv [NODES];
  prio_t            np [NODES];
  logic [SRC_W-1:0] ni [NODES];

  assign nv[0] = 1'b0;
  assign np[0] = '0;
  assign ni[0] = '0;

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    if (g < NUM_SRC) begin : g_real
      assign nv[LEAVES+g] = req[g];
      assign np[LEAVES+g] = prio[g*PRIO_W +: PRIO_W];
      assign ni[LEAVES+g] = SRC_W'(g);
    end else begin : g_pad
      assign nv[LEAVES+g] = 1'b0;
      assign np[LEAVES+g] = '0;
      assign ni[LEAVES+g] = '0;
    end
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_left;
    // left subtree holds lower numbers, so it keeps ties
    assign take_left = nv[2*n] && (!nv[2*n+1] || (np[2*n] >= np[2*n+1]));
    assign nv[n] = nv[2*n] | nv[2*n+1];
    assign np[n] = take_left ? np[2*n] : np[2*n+1];
    assign ni[n] = take_left ? ni[2*n] : ni[2*n+1];
  end

  assign win_valid = nv[1];
  assign win_prio  = np[1];
  assign win_idx   = ni[1];
endmodule

// File: rtl/nia_level_stack.sv
module nia_level_stack
  import nia_pkg::*;
#(
  parameter int STACK_DEPTH = 8,
  parameter int DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  prio_t         din,
  output prio_t         top,
  output logic          empty,
  output logic [DW-1:0] depth
);
  localparam int PW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  prio_t         mem [STACK_DEPTH];
  logic [DW-1:0] cnt;
  logic [DW-1:0] top_ptr;
  logic          full;

  assign full    = (cnt == DW'(STACK_DEPTH));
  assign empty   = (cnt == '0);
  assign top_ptr = cnt - DW'(1);
  assign top     = empty ? '0 : mem[top_ptr[PW-1:0]];
  assign depth   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + DW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - DW'(1);
    end
  end

  for (genvar e = 0; e < STACK_DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[e] <= '0;
      end else if (push && !full && (cnt[PW-1:0] == PW'(e))) begin
        mem[e] <= din;
      end
    end
  end
endmodule

// File: rtl/nia_level_ctrl.sv
module nia_level_ctrl
  import nia_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  win_valid,
  input  prio_t win_prio,
  input  logic  vec_rd,
  input  logic  eoi_wr,
  input  prio_t stk_top,
  input  logic  stk_empty,
  output logic  irq,
  output logic  push,
  output logic  pop,
  output prio_t level,
  output logic  active
);
  logic take;

  assign irq  = win_valid && (!active || (win_prio > level));
  assign take = vec_rd && irq;
  // read and end-of-interrupt together: swap in place, stack untouched
  assign push = take && active && !eoi_wr;
  assign pop  = eoi_wr && !take && !stk_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      active <= 1'b0;
    end else if (take) begin
      level  <= win_prio;
      active <= 1'b1;
    end else if (eoi_wr) begin
      if (!stk_empty) begin
        level <= stk_top;
      end else begin
        level  <= '0;
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
  import nia_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int STACK_DEPTH = 8,
  parameter int SRC_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int DW          = $clog2(STACK_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_pending,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  output logic                      irq_o,
  input  logic                      vec_rd,
  output logic [SRC_W:0]            vec_data,
  input  logic                      eoi_wr,
  output logic [PRIO_W-1:0]         cur_level,
  output logic                      in_service,
  output logic [DW-1:0]             nest_depth
);
  logic             win_valid;
  prio_t            win_prio;
  logic [SRC_W-1:0] win_idx;
  logic             push, pop, stk_empty;
  prio_t            stk_top, level;

  nia_prio_tree #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_tree (
    .req(src_pending), .prio(src_prio),
    .win_valid(win_valid), .win_prio(win_prio), .win_idx(win_idx)
  );

  nia_level_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_prio(win_prio),
    .vec_rd(vec_rd), .eoi_wr(eoi_wr), .stk_top(stk_top), .stk_empty(stk_empty),
    .irq(irq_o), .push(push), .pop(pop), .level(level), .active(in_service)
  );

  nia_level_stack #(.STACK_DEPTH(STACK_DEPTH), .DW(DW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(level),
    .top(stk_top), .empty(stk_empty), .depth(nest_depth)
  );

  assign cur_level = level;
  assign vec_data  = irq_o ? {1'b0, win_idx} : '1;
endmodule

// File: rtl/nia_checker.sv
module nia_checker
  import nia_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int STACK_DEPTH = 8,
  parameter int SRC_W       = 5,
  parameter int DW          = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        src_pending,
  input logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input logic                      irq_o,
  input logic                      vec_rd,
  input logic [SRC_W:0]            vec_data,
  input logic                      eoi_wr,
  input logic [PRIO_W-1:0]         cur_level,
  input logic                      in_service,
  input logic [DW-1:0]             nest_depth
);
  prio_t sel_prio;
  always_comb begin
    sel_prio = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (vec_data == (SRC_W+1)'(k)) sel_prio = src_prio[k*PRIO_W +: PRIO_W];
    end
  end

  a_r3_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|src_pending));

  a_r4_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_data == '1));

  a_r5_read_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_o) |=> (in_service && cur_level == $past(sel_prio)));

  a_r6_nested_push: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_o && in_service && !eoi_wr && nest_depth < DW'(STACK_DEPTH))
      |=> ((nest_depth - $past(nest_depth)) == DW'(1)));

  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_o && !eoi_wr && nest_depth == DW'(STACK_DEPTH)) |=> $stable(nest_depth));

  a_r7_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !vec_rd && nest_depth == '0) |=> (!in_service && cur_level == '0));

  a_r8_spurious_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !irq_o && !eoi_wr) |=>
      ($stable(nest_depth) && $stable(cur_level) && $stable(in_service)));

  a_r9_swap_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_o && eoi_wr && in_service) |=> $stable(nest_depth));

  a_r10_idle_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !in_service |-> (nest_depth == '0 && cur_level == '0));
endmodule

bind nest_irq_arbiter nia_checker #(
  .NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH), .SRC_W(SRC_W), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pending(src_pending), .src_prio(src_prio),
  .irq_o(irq_o), .vec_rd(vec_rd), .vec_data(vec_data), .eoi_wr(eoi_wr),
  .cur_level(cur_level), .in_service(in_service), .nest_depth(nest_depth)
);

// File: tb/tb_nest_irq_arbiter.sv
module tb_nest_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] pend = '0;
  logic [95:0] prio = '0;
  logic        rd = 1'b0, eoi = 1'b0;
  logic        irq, insvc;
  logic [5:0]  vec;
  logic [2:0]  lvl;
  logic [3:0]  dep;

  nest_irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_prio(prio),
    .irq_o(irq), .vec_rd(rd), .vec_data(vec), .eoi_wr(eoi),
    .cur_level(lvl), .in_service(insvc), .nest_depth(dep)
  );

  logic [7:0]  s_pend = '0;
  logic [23:0] s_prio = '0;
  logic        s_rd = 1'b0, s_eoi = 1'b0;
  logic        s_irq, s_insvc;
  logic [3:0]  s_vec;
  logic [2:0]  s_lvl;
  logic [1:0]  s_dep;

  nest_irq_arbiter #(.NUM_SRC(8), .STACK_DEPTH(2)) dut_small (
    .clk(clk), .rst_n(rst_n), .src_pending(s_pend), .src_prio(s_prio),
    .irq_o(s_irq), .vec_rd(s_rd), .vec_data(s_vec), .eoi_wr(s_eoi),
    .cur_level(s_lvl), .in_service(s_insvc), .nest_depth(s_dep)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] pend;
    logic [1:0]  mode;
    logic [5:0]  exp;
  } row_t;

  // mode 0: all zero, 1: i%8, 2: 7-i%8
  localparam row_t TABLE [10] = '{
    '{32'h0000_0000, 2'd0, 6'd63},
    '{32'h0000_0001, 2'd0, 6'd0},
    '{32'h8000_0000, 2'd0, 6'd31},
    '{32'hFFFF_FFFF, 2'd0, 6'd0},
    '{32'hFFFF_FFFF, 2'd1, 6'd7},
    '{32'hFFFF_FF00, 2'd1, 6'd15},
    '{32'hFFFF_FFFF, 2'd2, 6'd0},
    '{32'h0000_0006, 2'd2, 6'd1},
    '{32'h8000_0080, 2'd1, 6'd7},
    '{32'h0001_0010, 2'd1, 6'd4}
  };

  function automatic logic [95:0] mk_prio(logic [1:0] m);
    logic [95:0] p = '0;
    for (int i = 0; i < 32; i++) begin
      if (m == 2'd1) p[i*3 +: 3] = 3'(i % 8);
      else if (m == 2'd2) p[i*3 +: 3] = 3'(7 - i % 8);
    end
    return p;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(bit r, bit e);
    step(); rd = r; eoi = e;
    step(); rd = 1'b0; eoi = 1'b0;
    #1;
  endtask

  task automatic s_read();
    step(); s_rd = 1'b1;
    step(); s_rd = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    #1;
    chk("R10 reset irq", irq, 0);
    chk("R10 reset in_service", insvc, 0);
    chk("R10 reset level", lvl, 0);
    chk("R10 reset depth", dep, 0);
    chk("R4 reset vector", vec, 63);
    step(); rst_n = 1'b1;

    // R1 R2 R3 R4: idle selection table
    foreach (TABLE[i]) begin
      step();
      pend = TABLE[i].pend;
      prio = mk_prio(TABLE[i].mode);
      #1;
      chk($sformatf("R1 R2 R4 row %0d vector", i), vec, TABLE[i].exp);
      chk($sformatf("R3 row %0d irq", i), irq, (TABLE[i].pend != 0) ? 1 : 0);
    end

    // R4: higher source arrives before the read
    step(); pend = '0; prio = '0;
    prio[3*3 +: 3] = 3'd2; prio[5*3 +: 3] = 3'd6;
    prio[9*3 +: 3] = 3'd7; prio[10*3 +: 3] = 3'd7;
    pend[3] = 1'b1;
    #1; chk("R3 idle irq", irq, 1); chk("R4 first vector", vec, 3);
    step(); pend[5] = 1'b1;
    #1; chk("R4 preempt before read", vec, 5);
    pulse(1, 0);
    chk("R5 level after read", lvl, 6);
    chk("R5 in_service", insvc, 1);
    chk("R5 irq dropped", irq, 0);
    chk("R6 idle read no push", dep, 0);

    // R6: nested
    step(); pend[9] = 1'b1;
    #1; chk("R3 higher reasserts", irq, 1); chk("R4 nested vector", vec, 9);
    pulse(1, 0);
    chk("R6 nested level", lvl, 7);
    chk("R6 nested depth", dep, 1);

    // R8: spurious
    #1; chk("R8 spurious vector", vec, 63);
    pulse(1, 0);
    chk("R8 level held", lvl, 7);
    chk("R8 depth held", dep, 1);
    chk("R8 in_service held", insvc, 1);

    // R7: pop
    step(); pend[9] = 1'b0;
    pulse(0, 1);
    chk("R7 popped level", lvl, 6);
    chk("R7 depth after pop", dep, 0);
    chk("R7 still in service", insvc, 1);
    chk("R3 equal prio no irq", irq, 0);

    // R9: read and end-of-interrupt together
    step(); pend[10] = 1'b1;
    #1; chk("R9 vector before swap", vec, 10);
    pulse(1, 1);
    chk("R9 swapped level", lvl, 7);
    chk("R9 depth unchanged", dep, 0);
    chk("R9 in_service", insvc, 1);

    // R7: empty pop returns to idle
    step(); pend[10] = 1'b0;
    pulse(0, 1);
    chk("R7 idle after empty pop", insvc, 0);
    chk("R7 level zero", lvl, 0);
    chk("R3 idle irq again", irq, 1);
    chk("R4 idle vector", vec, 5);

    // R6: full stack on the small instance
    step();
    for (int i = 0; i < 4; i++) s_prio[i*3 +: 3] = 3'(i + 1);
    for (int i = 0; i < 4; i++) begin
      step(); s_pend[i] = 1'b1;
      s_read();
    end
    chk("R6 full depth held", s_dep, 2);
    chk("R6 level after full push", s_lvl, 4);
    step(); s_pend = '0; s_eoi = 1'b1;
    step(); s_eoi = 1'b0;
    #1;
    chk("R6 pop after dropped push", s_lvl, 2);
    chk("R6 depth after pop", s_dep, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule